// File: doc/BRIEF.md
# Program-Memory Table Access Unit

This unit moves one byte at a time between a byte-addressed program memory and a byte-wide table latch. It keeps a 21-bit table pointer, which the host fills in three byte-wide pieces and can read back at any time. The host can also load and read the latch directly.

A host request names a direction (read or write) and one of four pointer modes. A read fetches the memory byte at the effective address into the latch. A write sends the latch byte to the effective address. The pointer is then left as the mode requires. The memory side is a plain synchronous port with separate read and write strobes and one cycle of read latency.

While an access is in flight the unit shows `busy`. It finishes each access with a one-cycle `done` pulse. Anything the host drives during `busy` is dropped.

Top module: `tblx_unit`

## Requirements
- R1: After reset the pointer and the latch read 0, `busy` and `done` are low, and neither memory strobe is active.
- R2: When the unit is idle and no request is present, `ptr_ld_upper` loads pointer bits 20:16 from `ptr_ld_data[4:0]`, `ptr_ld_high` loads bits 15:8, and `ptr_ld_low` loads bits 7:0. All other pointer bits are kept. `ptr_q` shows the whole pointer from the next cycle on.
- R3: When the unit is idle and no request is present, `lat_ld` loads `lat_ld_data` into the latch. The new value is visible on `lat_q` in the next cycle.
- R4: A read request taken in cycle T drives `mem_rd` for exactly one cycle (T+1) at the effective address. The latch takes `mem_rdata` one cycle after the strobe, and `done` pulses in T+3.
- R5: A write request taken in cycle T drives `mem_wr` for exactly one cycle (T+1), with the latch value on `mem_wdata` and the effective address on `mem_addr`. `done` pulses in T+2.
- R6: Mode 2'b00 accesses at the current pointer and leaves the pointer unchanged.
- R7: Mode 2'b01 accesses at the current pointer and then adds one to the pointer.
- R8: Mode 2'b10 accesses at the current pointer and then subtracts one from the pointer.
- R9: Mode 2'b11 adds one to the pointer first and accesses at the incremented address.
- R10: Pointer arithmetic wraps modulo 2^21: 0x1FFFFF plus one gives 0, and 0 minus one gives 0x1FFFFF.
- R11: `busy` is high from the cycle after a request is taken until the cycle before `done`. While it is high, requests, pointer loads and latch loads are ignored, and the pointer does not change.
- R12: If a request arrives in an idle cycle together with a pointer or latch load, the request is taken and the load is dropped.
- R13: `done` is a single-cycle pulse and is never high together with `busy`. `mem_rd` and `mem_wr` are never active in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Access request, taken when the unit is idle |
| req_write | input | 1 | 1 = write latch to memory, 0 = read memory into latch |
| req_mode | input | 2 | Pointer mode: 00 hold, 01 post-increment, 10 post-decrement, 11 pre-increment |
| ptr_ld_upper | input | 1 | Load pointer bits 20:16 |
| ptr_ld_high | input | 1 | Load pointer bits 15:8 |
| ptr_ld_low | input | 1 | Load pointer bits 7:0 |
| ptr_ld_data | input | 8 | Data for the pointer piece loads |
| ptr_q | output | 21 | Current pointer |
| lat_ld | input | 1 | Load the latch from `lat_ld_data` |
| lat_ld_data | input | 8 | Latch load data |
| lat_q | output | 8 | Current latch contents |
| busy | output | 1 | Access in progress |
| done | output | 1 | One-cycle completion pulse |
| mem_addr | output | 21 | Memory byte address |
| mem_rd | output | 1 | Memory read strobe |
| mem_wr | output | 1 | Memory write strobe |
| mem_wdata | output | 8 | Memory write data |
| mem_rdata | input | 8 | Memory read data, valid the cycle after `mem_rd` |

## Verification
The assertions check, on every cycle, that the strobes exclude each other and occur only while busy. They also check that `done` is a lone pulse outside busy, that each strobe is followed by `done` after the fixed latency, and that the pointer and latch stay frozen while an access is open.

Only the bench scenarios can show the values themselves: which address each mode produces, where the pointer ends up (including the wrap at both ends), which byte lands in the latch or on the write bus, and that loads dropped during busy or in a collision with a request leave no trace.

// File: rtl/tblx_pkg.sv
package tblx_pkg;

   typedef enum logic [1:0] {
      MODE_HOLD    = 2'b00,
      MODE_POSTINC = 2'b01,
      MODE_POSTDEC = 2'b10,
      MODE_PREINC  = 2'b11
   } tbl_mode_e;

   typedef enum logic [1:0] {
      ST_IDLE   = 2'b00,
      ST_ACCESS = 2'b01,
      ST_RESP   = 2'b10
   } tbl_state_e;

endpackage

// File: rtl/tblx_ptr.sv
module tblx_ptr
   import tblx_pkg::*;
#(
   parameter int PTR_W  = 21,
   parameter int LOAD_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              accept,
   input  tbl_mode_e         mode,
   input  logic              ld_en,
   input  logic              ld_upper,
   input  logic              ld_high,
   input  logic              ld_low,
   input  logic [LOAD_W-1:0] ld_data,
   output logic [PTR_W-1:0]  ptr_q,
   output logic [PTR_W-1:0]  eff_addr
);
   localparam int UP_W  = PTR_W - 2*LOAD_W;
   localparam int UP_LO = 2*LOAD_W;

   logic [PTR_W-1:0] ptr_inc;
   logic [PTR_W-1:0] ptr_dec;
   logic [UP_W-1:0]  up_piece;

   // Arithmetic is modulo 2^PTR_W by width alone.
   assign ptr_inc  = ptr_q + PTR_W'(1);
   assign ptr_dec  = ptr_q - PTR_W'(1);
   assign eff_addr = (mode == MODE_PREINC) ? ptr_inc : ptr_q;

   generate
      if (UP_W == LOAD_W) begin : g_up_full
         assign up_piece = ld_data;
      end else begin : g_up_part
         assign up_piece = ld_data[UP_W-1:0];
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         ptr_q <= '0;
      end else if (accept) begin
         unique case (mode)
            MODE_HOLD:    ptr_q <= ptr_q;
            MODE_POSTDEC: ptr_q <= ptr_dec;
            default:      ptr_q <= ptr_inc;
         endcase
      end else if (ld_en) begin
         if (ld_upper) ptr_q[PTR_W-1:UP_LO]      <= up_piece;
         if (ld_high)  ptr_q[UP_LO-1:LOAD_W]     <= ld_data;
         if (ld_low)   ptr_q[LOAD_W-1:0]         <= ld_data;
      end
   end
endmodule

// File: rtl/tblx_seq.sv
module tblx_seq
   import tblx_pkg::*;
#(
   parameter int PTR_W = 21
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             req_valid,
   input  logic             req_write,
   input  logic [PTR_W-1:0] eff_addr,
   output logic             accept,
   output logic             idle,
   output logic             capture,
   output logic             busy,
   output logic             done,
   output logic [PTR_W-1:0] mem_addr,
   output logic             mem_rd,
   output logic             mem_wr
);
   tbl_state_e state_q;
   logic       is_wr_q;

   assign idle    = (state_q == ST_IDLE);
   assign accept  = idle && req_valid;
   assign busy    = !idle;
   assign capture = (state_q == ST_RESP);
   assign mem_rd  = (state_q == ST_ACCESS) && !is_wr_q;
   assign mem_wr  = (state_q == ST_ACCESS) &&  is_wr_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state_q  <= ST_IDLE;
         is_wr_q  <= 1'b0;
         mem_addr <= '0;
         done     <= 1'b0;
      end else begin
         done <= 1'b0;
         unique case (state_q)
            ST_IDLE: begin
               if (req_valid) begin
                  mem_addr <= eff_addr;
                  is_wr_q  <= req_write;
                  state_q  <= ST_ACCESS;
               end
            end
            ST_ACCESS: begin
               if (is_wr_q) begin
                  state_q <= ST_IDLE;
                  done    <= 1'b1;
               end else begin
                  state_q <= ST_RESP;
               end
            end
            default: begin
               state_q <= ST_IDLE;
               done    <= 1'b1;
            end
         endcase
      end
   end
endmodule

// File: rtl/tblx_latch.sv
module tblx_latch #(
   parameter int DATA_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              capture,
   input  logic [DATA_W-1:0] rdata,
   input  logic              ld_en,
   input  logic              ld,
   input  logic [DATA_W-1:0] ld_data,
   output logic [DATA_W-1:0] lat_q
);
   always_ff @(posedge clk) begin
      if (!rst_n)             lat_q <= '0;
      else if (capture)       lat_q <= rdata;
      else if (ld_en && ld)   lat_q <= ld_data;
   end
endmodule

// File: rtl/tblx_unit.sv
module tblx_unit
   import tblx_pkg::*;
#(
   parameter int PTR_W  = 21,
   parameter int DATA_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_valid,
   input  logic              req_write,
   input  logic [1:0]        req_mode,
   input  logic              ptr_ld_upper,
   input  logic              ptr_ld_high,
   input  logic              ptr_ld_low,
   input  logic [DATA_W-1:0] ptr_ld_data,
   output logic [PTR_W-1:0]  ptr_q,
   input  logic              lat_ld,
   input  logic [DATA_W-1:0] lat_ld_data,
   output logic [DATA_W-1:0] lat_q,
   output logic              busy,
   output logic              done,
   output logic [PTR_W-1:0]  mem_addr,
   output logic              mem_rd,
   output logic              mem_wr,
   output logic [DATA_W-1:0] mem_wdata,
   input  logic [DATA_W-1:0] mem_rdata
);
   generate
      if (PTR_W <= 2*DATA_W || PTR_W > 3*DATA_W) begin : g_bad_ptr_w
         $error("tblx_unit: PTR_W must fit in three load pieces with a non-empty top piece");
      end
   endgenerate

   logic             accept;
   logic             idle;
   logic             capture;
   logic             ld_en;
   logic [PTR_W-1:0] eff_addr;

   // Loads only land in idle cycles that carry no request.
   assign ld_en     = idle && !req_valid;
   assign mem_wdata = lat_q;

   tblx_ptr #(.PTR_W(PTR_W), .LOAD_W(DATA_W)) u_ptr (
      .clk      (clk),
      .rst_n    (rst_n),
      .accept   (accept),
      .mode     (tbl_mode_e'(req_mode)),
      .ld_en    (ld_en),
      .ld_upper (ptr_ld_upper),
      .ld_high  (ptr_ld_high),
      .ld_low   (ptr_ld_low),
      .ld_data  (ptr_ld_data),
      .ptr_q    (ptr_q),
      .eff_addr (eff_addr)
   );

   tblx_seq #(.PTR_W(PTR_W)) u_seq (
      .clk       (clk),
      .rst_n     (rst_n),
      .req_valid (req_valid),
      .req_write (req_write),
      .eff_addr  (eff_addr),
      .accept    (accept),
      .idle      (idle),
      .capture   (capture),
      .busy      (busy),
      .done      (done),
      .mem_addr  (mem_addr),
      .mem_rd    (mem_rd),
      .mem_wr    (mem_wr)
   );

   tblx_latch #(.DATA_W(DATA_W)) u_latch (
      .clk     (clk),
      .rst_n   (rst_n),
      .capture (capture),
      .rdata   (mem_rdata),
      .ld_en   (ld_en),
      .ld      (lat_ld),
      .ld_data (lat_ld_data),
      .lat_q   (lat_q)
   );
endmodule

// File: rtl/tblx_unit_chk.sv
module tblx_unit_chk #(
   parameter int PTR_W  = 21,
   parameter int DATA_W = 8
) (
   input logic              clk,
   input logic              rst_n,
   input logic              busy,
   input logic              done,
   input logic              mem_rd,
   input logic              mem_wr,
   input logic [PTR_W-1:0]  ptr_q,
   input logic [DATA_W-1:0] lat_q
);
   AST_NO_DUAL_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
      !(mem_rd && mem_wr));                                     // R13
   AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);                                          // R13
   AST_DONE_NOT_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> !busy);                                          // R13
   AST_STROBE_IN_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_rd || mem_wr) |-> busy);                             // R11
   AST_PTR_FROZEN_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
      busy |=> $stable(ptr_q));                                 // R11
   AST_LAT_FROZEN_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
      mem_wr |=> $stable(lat_q));                               // R11
   AST_WR_DONE_NEXT: assert property (@(posedge clk) disable iff (!rst_n)
      mem_wr |=> done);                                         // R5
   AST_RD_DONE_LATER: assert property (@(posedge clk) disable iff (!rst_n)
      mem_rd |=> ##1 done);                                     // R4
endmodule

bind tblx_unit tblx_unit_chk #(.PTR_W(PTR_W), .DATA_W(DATA_W)) u_chk (
   .clk    (clk),
   .rst_n  (rst_n),
   .busy   (busy),
   .done   (done),
   .mem_rd (mem_rd),
   .mem_wr (mem_wr),
   .ptr_q  (ptr_q),
   .lat_q  (lat_q)
);

// File: tb/tblx_unit_test.sv
module tblx_unit_test;
   localparam int PW = 21;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          req_valid = 1'b0, req_write = 1'b0;
   logic [1:0]    req_mode = 2'b00;
   logic          ptr_ld_upper = 1'b0, ptr_ld_high = 1'b0, ptr_ld_low = 1'b0;
   logic [7:0]    ptr_ld_data = '0;
   logic [PW-1:0] ptr_q;
   logic          lat_ld = 1'b0;
   logic [7:0]    lat_ld_data = '0;
   logic [7:0]    lat_q;
   logic          busy, done;
   logic [PW-1:0] mem_addr;
   logic          mem_rd, mem_wr;
   logic [7:0]    mem_wdata;
   logic [7:0]    mem_rdata = '0;

   int n_chk = 0, n_fail = 0, cyc = 0;
   int rd_cnt = 0, wr_cnt = 0;
   logic [PW-1:0] last_rd_addr = '0, last_wr_addr = '0;
   logic [7:0]    last_wr_data = '0;

   always #2 clk = ~clk;   // 250 MHz

   tblx_unit uut (.*);

   function automatic logic [7:0] mem_byte(input logic [PW-1:0] a);
      return a[7:0] ^ a[15:8] ^ {3'b000, a[20:16]} ^ 8'h5A;
   endfunction

   // Memory model with one cycle of read latency, plus strobe monitor.
   always @(posedge clk) begin
      cyc <= cyc + 1;
      if (mem_rd) begin
         mem_rdata    <= mem_byte(mem_addr);
         rd_cnt       <= rd_cnt + 1;
         last_rd_addr <= mem_addr;
      end
      if (mem_wr) begin
         wr_cnt       <= wr_cnt + 1;
         last_wr_addr <= mem_addr;
         last_wr_data <= mem_wdata;
      end
   end

   always @(posedge clk) if (cyc > 20000) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: run hung (act cyc=%0d exp <=20000)", cyc);
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

   task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s: act=%h exp=%h", req, act, exp);
      end
   endtask

   task automatic set_ptr(input logic [PW-1:0] p);
      @(negedge clk); ptr_ld_upper = 1; ptr_ld_data = {3'b000, p[20:16]};
      @(negedge clk); ptr_ld_upper = 0; ptr_ld_high = 1; ptr_ld_data = p[15:8];
      @(negedge clk); ptr_ld_high = 0; ptr_ld_low = 1; ptr_ld_data = p[7:0];
      @(negedge clk); ptr_ld_low = 0;
   endtask

   task automatic set_lat(input logic [7:0] v);
      @(negedge clk); lat_ld = 1; lat_ld_data = v;
      @(negedge clk); lat_ld = 0;
   endtask

   // Issue one request and return the number of negedges until done.
   task automatic issue(input bit wr, input logic [1:0] md, output int lat);
      @(negedge clk); req_valid = 1; req_write = wr; req_mode = md;
      lat = 0;
      for (int k = 1; k <= 8; k++) begin
         @(negedge clk);
         req_valid = 0;
         if (done && lat == 0) lat = k;
      end
   endtask

   task automatic t_reset;
      chk(ptr_q == 0 && lat_q == 0, "R1 ptr/latch", {ptr_q[15:0], 8'h0, lat_q}, 0);
      chk(!busy && !done && !mem_rd && !mem_wr, "R1 flags",
          {busy, done, mem_rd, mem_wr}, 0);
   endtask

   task automatic t_ptr_load;
      set_ptr(21'h0ABCDE);
      chk(ptr_q == 21'h0ABCDE, "R2 three-piece load", ptr_q, 21'h0ABCDE);
      @(negedge clk); ptr_ld_high = 1; ptr_ld_data = 8'h11;
      @(negedge clk); ptr_ld_high = 0;
      chk(ptr_q == 21'h0A11DE, "R2 high piece only", ptr_q, 21'h0A11DE);
      @(negedge clk); ptr_ld_upper = 1; ptr_ld_data = 8'hFF;
      @(negedge clk); ptr_ld_upper = 0;
      chk(ptr_q == 21'h1F11DE, "R2 upper uses 5 bits", ptr_q, 21'h1F11DE);
   endtask

   task automatic t_latch_load;
      set_lat(8'hC3);
      chk(lat_q == 8'hC3, "R3 latch load", lat_q, 8'hC3);
   endtask

   task automatic t_read(input logic [1:0] md, input logic [PW-1:0] p,
                         input logic [PW-1:0] ea, input logic [PW-1:0] np, input string req);
      int lat, rc;
      set_ptr(p);
      rc = rd_cnt;
      issue(1'b0, md, lat);
      chk(lat == 3, "R4 read latency", lat, 3);
      chk(rd_cnt == rc + 1 && last_rd_addr == ea, {req, " read addr"}, last_rd_addr, ea);
      chk(lat_q == mem_byte(ea), "R4 latch data", lat_q, mem_byte(ea));
      chk(ptr_q == np, {req, " read ptr"}, ptr_q, np);
   endtask

   task automatic t_write(input logic [1:0] md, input logic [PW-1:0] p,
                          input logic [PW-1:0] ea, input logic [PW-1:0] np, input string req);
      int lat, wc, rc;
      set_ptr(p);
      set_lat(p[7:0] ^ 8'hA5);
      wc = wr_cnt; rc = rd_cnt;
      issue(1'b1, md, lat);
      chk(lat == 2, "R5 write latency", lat, 2);
      chk(wr_cnt == wc + 1 && rd_cnt == rc && last_wr_addr == ea, {req, " write addr"}, last_wr_addr, ea);
      chk(last_wr_data == (p[7:0] ^ 8'hA5), "R5 write data", last_wr_data, p[7:0] ^ 8'hA5);
      chk(ptr_q == np, {req, " write ptr"}, ptr_q, np);
   endtask

   task automatic t_busy_ignore;
      int wc, rc;
      set_ptr(21'h000100);
      wc = wr_cnt; rc = rd_cnt;
      @(negedge clk); req_valid = 1; req_write = 0; req_mode = 2'b00;
      @(negedge clk);
      chk(busy, "R11 busy after accept", busy, 1);
      req_write = 1; req_mode = 2'b11; ptr_ld_low = 1; ptr_ld_data = 8'hAA;
      lat_ld = 1; lat_ld_data = 8'h33;
      @(negedge clk);
      req_valid = 0; ptr_ld_low = 0; lat_ld = 0;
      chk(busy && !done, "R11 busy second cycle", {busy, done}, 2'b10);
      @(negedge clk);
      chk(done && !busy, "R13 done pulse", {busy, done}, 2'b01);
      repeat (4) @(negedge clk);
      chk(wr_cnt == wc && rd_cnt == rc + 1, "R11 request ignored", wr_cnt, wc);
      chk(ptr_q == 21'h000100, "R11 pointer load ignored", ptr_q, 21'h000100);
      chk(lat_q == mem_byte(21'h000100), "R11 latch load ignored", lat_q, mem_byte(21'h000100));
   endtask

   task automatic t_priority;
      int wc;
      set_ptr(21'h012340);
      set_lat(8'h5C);
      wc = wr_cnt;
      @(negedge clk); req_valid = 1; req_write = 1; req_mode = 2'b01;
      ptr_ld_low = 1; ptr_ld_data = 8'h77; lat_ld = 1; lat_ld_data = 8'h99;
      @(negedge clk); req_valid = 0; ptr_ld_low = 0; lat_ld = 0;
      repeat (4) @(negedge clk);
      chk(wr_cnt == wc + 1 && last_wr_addr == 21'h012340, "R12 request taken", last_wr_addr, 21'h012340);
      chk(last_wr_data == 8'h5C && lat_q == 8'h5C, "R12 latch load dropped", lat_q, 8'h5C);
      chk(ptr_q == 21'h012341, "R12 pointer load dropped", ptr_q, 21'h012341);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      t_reset();
      rst_n = 1;
      @(negedge clk);
      t_reset();
      t_ptr_load();
      t_latch_load();
      t_read (2'b00, 21'h000345, 21'h000345, 21'h000345, "R6");
      t_read (2'b01, 21'h000345, 21'h000345, 21'h000346, "R7");
      t_read (2'b10, 21'h0A0000, 21'h0A0000, 21'h09FFFF, "R8");
      t_read (2'b11, 21'h0012FF, 21'h001300, 21'h001300, "R9");
      t_write(2'b00, 21'h100020, 21'h100020, 21'h100020, "R6");
      t_write(2'b01, 21'h100020, 21'h100020, 21'h100021, "R7");
      t_write(2'b10, 21'h100020, 21'h100020, 21'h10001F, "R8");
      t_write(2'b11, 21'h100020, 21'h100021, 21'h100021, "R9");
      t_read (2'b01, 21'h1FFFFF, 21'h1FFFFF, 21'h000000, "R10 postinc wrap");
      t_read (2'b11, 21'h1FFFFF, 21'h000000, 21'h000000, "R10 preinc wrap");
      t_write(2'b10, 21'h000000, 21'h000000, 21'h1FFFFF, "R10 postdec wrap");
      t_busy_ignore();
      t_priority();
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end
endmodule